// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM with 128K locations. The RAM has two chip enables, one active low and one active high. The controller accepts one read or write at a time through a request/ready handshake. It then plays out the pin sequence the RAM needs: address, chip enables, output enable, write enable and the byte lane. The data lane is split into an outgoing byte, an incoming byte and a drive enable, so that the tristate buffer can sit at the pad ring.

Every interval is a parameter counted in system clock cycles. The integrator rounds each nanosecond figure up to whole clocks. The intervals are the read wait, the setup before the write strobe, the write strobe width, and the recovery time that ends each access. Read data is registered on the last wait cycle and handed back with a one-cycle valid strobe. The controller never drives the byte lane while the RAM might be driving it.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the RAM is deselected (`ram_sel_n`=1, `ram_sel`=0), `ram_oe_n`=1, `ram_we_n`=1, `ram_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: The two chip enables always move together, so that `ram_sel_n` equals the inverse of `ram_sel`. The RAM counts as selected only when `ram_sel_n`=0 and `ram_sel`=1.
- R3: For a read, the address and chip enables appear together for one cycle with `ram_oe_n` still high. `ram_oe_n` then stays low for exactly RD_WAIT_CYC cycles while `ram_we_n` stays high.
- R4: Each read produces exactly one `rsp_valid` pulse, one cycle long, in the cycle after the last output-enable cycle. `rsp_rdata` then holds the byte that was on `ram_dq_in` in that last cycle. A write produces no pulse.
- R5: For a write, the RAM is selected for WR_SETUP_CYC cycles with `ram_we_n` high. Then `ram_we_n` is low for exactly WR_PULSE_CYC consecutive cycles.
- R6: `ram_dq_oe` is 1 exactly when `ram_we_n` is 0. `ram_oe_n` and `ram_we_n` are never low at the same time.
- R7: While `ram_we_n` is low, `ram_addr` and `ram_dq_out` do not change. The byte stored is the one given with the request.
- R8: Every access ends with RECOVER_CYC cycles in which the RAM is deselected, `ram_oe_n`=1 and the lane is not driven. As a result, a cycle with `ram_oe_n` low is never directly followed by a cycle with `ram_dq_oe`=1.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 for 2+RD_WAIT_CYC+RECOVER_CYC cycles for a read, and for WR_SETUP_CYC+WR_PULSE_CYC+RECOVER_CYC cycles for a write.
- R10: `req_valid` asserted while `req_ready`=0 has no effect. No RAM location changes and no extra access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_dq_out | output | DATA_W | Byte driven onto the RAM lane |
| ram_dq_in | input | DATA_W | Byte seen on the RAM lane |
| ram_dq_oe | output | 1 | Lane drive enable |
| ram_sel_n | output | 1 | Active-low chip enable |
| ram_sel | output | 1 | Active-high chip enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |

## Verification
Some properties are checked on every cycle:
- the two enables stay paired;
- drive and write strobe stay locked together;
- the output and write strobes never overlap;
- output enable always follows a selected address cycle;
- address and data hold still under the strobe;
- an output-enable cycle is never followed by a drive cycle;
- the valid strobe lasts one cycle;
- ready drops after acceptance and comes back only with the RAM released.

Other properties need the bench's RAM model and transaction scenarios. These are the exact strobe widths and busy lengths, whether the correct byte lands in every location and returns intact, and whether requests made while busy leave memory untouched.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SEL,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_RECOVER
    } asc_state_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic drive;
        logic ready;
        logic rsp;
    } asc_pins_t;

    // Pin levels are a pure function of the registered state.
    function automatic asc_pins_t pins_for(asc_state_e s);
        asc_pins_t p;
        p = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1,
              drive: 1'b0, ready: 1'b0, rsp: 1'b0};
        case (s)
            ST_IDLE:     p.ready = 1'b1;
            ST_RD_SEL:   begin p.sel_n = 1'b0; p.sel = 1'b1; end
            ST_RD_WAIT:  begin p.sel_n = 1'b0; p.sel = 1'b1; p.oe_n = 1'b0; end
            ST_RD_DONE:  p.rsp = 1'b1;
            ST_WR_SETUP: begin p.sel_n = 1'b0; p.sel = 1'b1; end
            ST_WR_PULSE: begin p.sel_n = 1'b0; p.sel = 1'b1; p.we_n = 1'b0; p.drive = 1'b1; end
            default:     ;
        endcase
        return p;
    endfunction

    // Bits needed to hold the value n-1 (at least one bit).
    function automatic int cnt_bits(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/asc_interval_cnt.sv
module asc_interval_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asc_seq.sv
module asc_seq
    import asc_pkg::*;
#(
    parameter int CW           = 2,
    parameter int RD_WAIT_CYC  = 2,
    parameter int WR_SETUP_CYC = 1,
    parameter int WR_PULSE_CYC = 2,
    parameter int RECOVER_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          expired,
    output asc_state_e    state,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          capture
);
    localparam logic [CW-1:0] LD_RD  = CW'(RD_WAIT_CYC - 1);
    localparam logic [CW-1:0] LD_SU  = CW'(WR_SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_WP  = CW'(WR_PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_REC = CW'(RECOVER_CYC - 1);

    asc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                if (req_write) begin
                    state_d  = ST_WR_SETUP;
                    load     = 1'b1;
                    load_val = LD_SU;
                end else begin
                    state_d = ST_RD_SEL;
                end
            end
            ST_RD_SEL: begin
                state_d  = ST_RD_WAIT;
                load     = 1'b1;
                load_val = LD_RD;
            end
            ST_RD_WAIT: if (expired) begin
                capture = 1'b1;
                state_d = ST_RD_DONE;
            end
            ST_RD_DONE: begin
                state_d  = ST_RECOVER;
                load     = 1'b1;
                load_val = LD_REC;
            end
            ST_WR_SETUP: if (expired) begin
                state_d  = ST_WR_PULSE;
                load     = 1'b1;
                load_val = LD_WP;
            end
            ST_WR_PULSE: if (expired) begin
                state_d  = ST_RECOVER;
                load     = 1'b1;
                load_val = LD_REC;
            end
            ST_RECOVER: if (expired) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/asc_hold.sv
module asc_hold #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= ram_dq_in;
        end
    end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import asc_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int RD_WAIT_CYC  = 2,
    parameter int WR_SETUP_CYC = 1,
    parameter int WR_PULSE_CYC = 2,
    parameter int RECOVER_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              ram_dq_oe,
    output logic              ram_sel_n,
    output logic              ram_sel,
    output logic              ram_oe_n,
    output logic              ram_we_n
);
    localparam int MAX_INT = max4(RD_WAIT_CYC, WR_SETUP_CYC, WR_PULSE_CYC, RECOVER_CYC);
    localparam int CW      = cnt_bits(MAX_INT);

    asc_state_e    state;
    asc_pins_t     pins;
    logic          load, expired, accept, capture;
    logic [CW-1:0] load_val;

    asc_interval_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
    );

    asc_seq #(
        .CW(CW), .RD_WAIT_CYC(RD_WAIT_CYC), .WR_SETUP_CYC(WR_SETUP_CYC),
        .WR_PULSE_CYC(WR_PULSE_CYC), .RECOVER_CYC(RECOVER_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .expired(expired), .state(state), .load(load), .load_val(load_val),
        .accept(accept), .capture(capture)
    );

    asc_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .ram_dq_in(ram_dq_in),
        .addr_q(ram_addr), .wdata_q(ram_dq_out), .rdata_q(rsp_rdata)
    );

    assign pins      = pins_for(state);
    assign ram_sel_n = pins.sel_n;
    assign ram_sel   = pins.sel;
    assign ram_oe_n  = pins.oe_n;
    assign ram_we_n  = pins.we_n;
    assign ram_dq_oe = pins.drive;
    assign req_ready = pins.ready;
    assign rsp_valid = pins.rsp;
endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_dq_out,
    input logic              ram_dq_oe,
    input logic              ram_sel_n,
    input logic              ram_sel,
    input logic              ram_oe_n,
    input logic              ram_we_n
);
    // R2
    enable_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ram_sel_n == !ram_sel);

    // R6
    drive_follows_we_chk: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe == !ram_we_n);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ram_oe_n && !ram_we_n));

    // R3
    oe_after_select_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_oe_n) |-> ($past(!ram_sel_n) && $past(ram_we_n)));

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ram_we_n && $past(!ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_dq_out)));

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |=> !ram_dq_oe);

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    ready_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> (ram_sel_n && ram_oe_n && ram_we_n && !ram_dq_oe));
endmodule

bind sram_port_ctrl asc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
);

// File: tb/sim_sram_port_ctrl.sv
module sim_sram_port_ctrl;
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int RDW  = 2;
    localparam int SU   = 1;
    localparam int WP   = 2;
    localparam int REC  = 1;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, ram_dq_oe, ram_sel_n, ram_sel, ram_oe_n, ram_we_n;
    logic [DW-1:0] rsp_rdata, ram_dq_out, ram_dq_in;
    logic [AW-1:0] ram_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sram_port_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_WAIT_CYC(RDW), .WR_SETUP_CYC(SU),
        .WR_PULSE_CYC(WP), .RECOVER_CYC(REC)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
        .ram_dq_out(ram_dq_out), .ram_dq_in(ram_dq_in), .ram_dq_oe(ram_dq_oe),
        .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n)
    );

    // RAM model: selected only for sel_n=0 and sel=1.
    logic [DW-1:0] model_mem [DEPTH];
    logic selected, model_drives;
    assign selected     = !ram_sel_n && ram_sel;
    assign model_drives = selected && !ram_oe_n && ram_we_n;
    assign ram_dq_in    = model_drives ? model_mem[ram_addr] : 8'hEE;

    // Monitor counters, sampled mid-cycle.
    int we_low = 0, rsp_seen = 0, pair_err = 0, clash_err = 0, turn_err = 0;
    int oe_low = 0;
    logic [DW-1:0] last_rd = '0;
    logic prev_oe_low = 1'b0;

    always @(negedge clk) if (!rst) begin
        if (ram_sel_n != !ram_sel) pair_err++;
        if (ram_dq_oe && model_drives) clash_err++;
        if (prev_oe_low && ram_dq_oe) turn_err++;
        prev_oe_low = !ram_oe_n;
        if (!ram_oe_n) oe_low++;
        if (!ram_we_n) we_low++;
        if (rsp_valid) begin rsp_seen++; last_rd = rsp_rdata; end
        if (selected && !ram_we_n && ram_dq_oe) model_mem[ram_addr] = ram_dq_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(int a, int salt);
        return DW'((a * 37 + 11 + salt * 101) & 8'hFF);
    endfunction

    // One access; with noise=1 a conflicting write is held on the request
    // lines for the whole busy window.
    task automatic access(input bit wr, input int a, input logic [DW-1:0] d,
                          input bit noise, input bit expect_rd, input logic [DW-1:0] exp_rd);
        int busy;
        @(negedge clk);
        we_low = 0; rsp_seen = 0; oe_low = 0;
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        busy = 0;
        @(negedge clk);
        while (!req_ready && busy < 100) begin
            busy++;
            if (noise) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = AW'(a ^ 1); req_wdata = 8'h5A;
            end else
                req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R9
        check(busy == (wr ? SU + WP + REC : 2 + RDW + REC), "R9 busy cycles",
              busy, wr ? SU + WP + REC : 2 + RDW + REC);
        if (wr) begin
            // R5
            check(we_low == WP, "R5 write strobe width", we_low, WP);
            // R4
            check(rsp_seen == 0, "R4 no strobe on write", rsp_seen, 0);
        end else begin
            // R3
            check(oe_low == RDW, "R3 output enable width", oe_low, RDW);
            // R4
            check(rsp_seen == 1, "R4 one strobe per read", rsp_seen, 1);
            if (expect_rd)
                check(last_rd == exp_rd, "R4 R7 read data", last_rd, exp_rd);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(req_ready && ram_sel_n && !ram_sel && ram_oe_n && ram_we_n &&
              !ram_dq_oe && !rsp_valid, "R1 reset pins", 0, 1);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && ram_sel_n && !ram_sel && ram_oe_n && ram_we_n &&
              !ram_dq_oe && !rsp_valid, "R1 after reset", 0, 1);

        // Fill every location, then read all back.
        for (int a = 0; a < DEPTH; a++) access(1'b1, a, pattern(a, 0), 1'b0, 1'b0, '0);
        for (int a = 0; a < DEPTH; a++) access(1'b0, a, '0, 1'b0, 1'b1, pattern(a, 0));

        // Alternating read/write back-to-back over a second pattern.
        for (int a = 0; a < DEPTH; a += 2) begin
            access(1'b0, a, '0, 1'b0, 1'b1, pattern(a, 0));
            access(1'b1, a, pattern(a, 1), 1'b0, 1'b0, '0);
        end
        for (int a = 0; a < DEPTH; a += 2)
            access(1'b0, a, '0, 1'b0, 1'b1, pattern(a, 1));

        // R10: writes held on the request lines while busy must not land.
        for (int a = 0; a < DEPTH; a += 16) begin
            access(1'b0, a, '0, 1'b1, 1'b1, pattern(a, (a % 2 == 0) ? 1 : 0));
            access(1'b1, a, pattern(a, 2), 1'b1, 1'b0, '0);
        end
        for (int a = 0; a < DEPTH; a += 16) begin
            // R10 neighbour untouched
            access(1'b0, a ^ 1, '0, 1'b0, 1'b1, pattern(a ^ 1, ((a ^ 1) % 2 == 0) ? 1 : 0));
            access(1'b0, a, '0, 1'b0, 1'b1, pattern(a, 2));
        end

        // R2 R6 R8 whole-run monitors
        check(pair_err == 0, "R2 enables paired", pair_err, 0);
        check(clash_err == 0, "R6 no bus contention", clash_err, 0);
        check(turn_err == 0, "R8 read-to-write turnaround", turn_err, 0);
        @(negedge clk);
        check(req_ready && ram_sel_n && !ram_dq_oe, "R8 released at end", 0, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule